// File: doc/BRIEF.md
# Dual-Rate Wake-Up Timer Bank with Setup-Word Sequencer

This block is the only source of activity in a low-power sensing node. A bank of countdown timers runs continuously. Each timer holds two reload values: a normal one for routine polling and an alternate one for periods when something of interest is being watched. A per-timer select input decides which of the two is loaded. When a timer runs out, it reloads itself and raises a request. The sequencer then walks through a short list of setup words held in an internal memory and presents them one at a time on the configuration output. The datapath uses each word to configure itself for one step.

The datapath acknowledges each step with a done pulse, and the sequencer then presents the next word. A flag in the word marks the end of the list, and the list also ends after a fixed maximum number of steps. The memory is split into banks, one per energy operating mode. The bank input is sampled when a sequence starts, so a mode change takes effect on the next sequence. A timer that expires while a sequence is running is held pending. Timers that expire together are served in fixed priority, lowest index first.

Top module: `wakeup_sequencer`

## Requirements
- R1: After reset, `tmr_fire`, `seq_active` and `cfg_valid` are low, both reload values of every timer are 0, and no timer fires and no sequence starts while every `tmr_en` bit stays low.
- R2: While `tmr_en[i]` is low, the count of timer i is loaded with its selected reload value R. Once `tmr_en[i]` is high, `tmr_fire[i]` pulses high for one cycle after R+1 enabled clock edges. It then fires again every R+1 cycles for as long as it stays enabled, reloading itself each time.
- R3: A write with `rl_we` high sets the reload of timer `rl_idx`: the alternate value when `rl_alt` is 1, the normal value when it is 0. `rate_sel[i]` = 1 makes timer i load the alternate value, and 0 makes it load the normal value.
- R4: `seq_active` rises one cycle after `tmr_fire` rises, with `seq_timer` giving the index of the timer being served. One cycle later `cfg_valid` rises, carrying the step-0 word on `cfg_word`.
- R5: The current word stays on `cfg_word` with `cfg_valid` high until `step_done` is sampled high. `cfg_valid` then goes low for one cycle, and the next step's word follows.
- R6: A memory word is `CFG_W+1` bits. Bit `CFG_W` is the end flag and the low `CFG_W` bits are the configuration. The write address is {bank, timer, step}, with step in the low bits. When `step_done` is accepted on a word whose end flag is set, `seq_active` and `cfg_valid` are low in the next cycle.
- R7: A sequence ends after its `N_STEP`-th word even when no end flag is set.
- R8: `bank_sel` is sampled when a sequence starts. Changing it during that sequence does not alter the words of that sequence.
- R9: When several timers fire in the same cycle, the lowest-numbered one is served first.
- R10: An expiry that occurs while a sequence is active is held pending and is not lost. Its sequence starts with `seq_active` low for exactly one cycle after the previous sequence ends.
- R11: `step_done` while `cfg_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | N_TMR | Per-timer run enable |
| rate_sel | input | N_TMR | Per-timer reload choice: 1 alternate, 0 normal |
| rl_we | input | 1 | Reload value write strobe |
| rl_idx | input | TI_W | Timer addressed by the reload write |
| rl_alt | input | 1 | 1 writes the alternate reload, 0 the normal one |
| rl_val | input | CNT_W | Reload value to write |
| mem_we | input | 1 | Setup memory write strobe |
| mem_addr | input | BK_W+TI_W+ST_W | Setup memory address {bank, timer, step} |
| mem_wdata | input | CFG_W+1 | Setup word {end flag, configuration} |
| bank_sel | input | BK_W | Energy-mode bank used by the next sequence |
| step_done | input | 1 | Datapath finished the current step |
| tmr_fire | output | N_TMR | One-cycle expiry pulse per timer |
| seq_active | output | 1 | A sequence is in progress |
| seq_timer | output | TI_W | Timer whose sequence is in progress |
| cfg_word | output | CFG_W | Configuration word of the current step |
| cfg_valid | output | 1 | `cfg_word` holds a valid step |

## Verification
The hardest situation to reach from the ports is a collision: two timers expire on the same edge while the bank input changes under a running sequence. The bench programs two timers with equal reloads and enables them on the same clock edge, so both fire together. It moves `bank_sel` as soon as the first sequence has started. It then confirms that the lower timer runs with the old bank and the held timer follows after a one-cycle gap with the new bank. Words without an end flag are written into one bank and timer slot, so the step limit is the only thing that can end that sequence.

// File: rtl/wakeup_seq_pkg.sv
package wakeup_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_APPLY = 2'd2
  } seq_state_t;

endpackage

// File: rtl/wseq_timer.sv
module wseq_timer #(
  parameter int CNT_W = 16,
  parameter int TI_W  = 2,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rate_sel,
  input  logic             rl_we,
  input  logic [TI_W-1:0]  rl_idx,
  input  logic             rl_alt,
  input  logic [CNT_W-1:0] rl_val,
  output logic             expire,
  output logic             fire
);

  logic [CNT_W-1:0] norm_q, alt_q, cnt_q, reload;

  assign reload = rate_sel ? alt_q : norm_q;
  assign expire = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      norm_q <= '0;
      alt_q  <= '0;
      cnt_q  <= '0;
      fire   <= 1'b0;
    end else begin
      if (rl_we && (rl_idx == TI_W'(IDX))) begin
        if (rl_alt) alt_q  <= rl_val;
        else        norm_q <= rl_val;
      end
      fire <= expire;
      if (!en || (cnt_q == '0)) cnt_q <= reload;
      else                      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/wseq_arbiter.sv
module wseq_arbiter #(
  parameter int N_TMR = 4,
  parameter int TI_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_TMR-1:0] expire,
  input  logic             take,
  output logic             grant_v,
  output logic [TI_W-1:0]  gnt_idx
);

  logic [N_TMR-1:0] pend_q, gnt_mask;

  always_comb begin
    gnt_idx = '0;
    for (int i = N_TMR - 1; i >= 0; i--) begin
      if (pend_q[i]) gnt_idx = TI_W'(i);
    end
    grant_v  = take && (|pend_q);
    gnt_mask = '0;
    if (grant_v) gnt_mask[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~gnt_mask) | expire;
  end

  // R10
  pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & ~gnt_mask)) |=>
      ((pend_q & $past(pend_q & ~gnt_mask)) == $past(pend_q & ~gnt_mask)));

endmodule

// File: rtl/wseq_setup_mem.sv
module wseq_setup_mem #(
  parameter int AW = 5,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/wseq_engine.sv
module wseq_engine
  import wakeup_seq_pkg::*;
#(
  parameter int TI_W   = 2,
  parameter int BK_W   = 1,
  parameter int ST_W   = 2,
  parameter int N_STEP = 4,
  parameter int CFG_W  = 16,
  localparam int AW    = BK_W + TI_W + ST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant_v,
  input  logic [TI_W-1:0]   gnt_idx,
  input  logic [BK_W-1:0]   bank_sel,
  input  logic              step_done,
  input  logic [CFG_W:0]    rd_data,
  output logic              take,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              seq_active,
  output logic [TI_W-1:0]   seq_timer,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              cfg_valid
);

  seq_state_t      state;
  logic [BK_W-1:0] bank_q;
  logic [ST_W-1:0] step_q, step_nx;
  logic            last_q, last_step;

  always_comb begin
    take      = (state == S_IDLE);
    step_nx   = step_q + 1'b1;
    last_step = last_q || (step_q == ST_W'(N_STEP - 1));
    rd_en     = (take && grant_v) ||
                ((state == S_APPLY) && step_done && !last_step);
    rd_addr   = take ? {bank_sel, gnt_idx, {ST_W{1'b0}}}
                     : {bank_q, seq_timer, step_nx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      bank_q     <= '0;
      step_q     <= '0;
      last_q     <= 1'b0;
      seq_active <= 1'b0;
      seq_timer  <= '0;
      cfg_word   <= '0;
      cfg_valid  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (grant_v) begin
          seq_timer  <= gnt_idx;
          bank_q     <= bank_sel;
          step_q     <= '0;
          seq_active <= 1'b1;
          state      <= S_FETCH;
        end
        S_FETCH: begin
          cfg_word  <= rd_data[CFG_W-1:0];
          last_q    <= rd_data[CFG_W];
          cfg_valid <= 1'b1;
          state     <= S_APPLY;
        end
        S_APPLY: if (step_done) begin
          cfg_valid <= 1'b0;
          if (last_step) begin
            seq_active <= 1'b0;
            state      <= S_IDLE;
          end else begin
            step_q <= step_nx;
            state  <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  cfg_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> seq_active);

  // R4
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_active) |=> cfg_valid);

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !step_done) |=> (cfg_valid && $stable(cfg_word)));

  // R6
  end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && step_done && last_q) |=> !seq_active);

endmodule

// File: rtl/wakeup_sequencer.sv
module wakeup_sequencer #(
  parameter int N_TMR  = 4,
  parameter int CNT_W  = 16,
  parameter int N_BANK = 2,
  parameter int N_STEP = 4,
  parameter int CFG_W  = 16,
  localparam int TI_W  = (N_TMR  > 1) ? $clog2(N_TMR)  : 1,
  localparam int BK_W  = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int ST_W  = (N_STEP > 1) ? $clog2(N_STEP) : 1,
  localparam int AW    = BK_W + TI_W + ST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_TMR-1:0] tmr_en,
  input  logic [N_TMR-1:0] rate_sel,
  input  logic             rl_we,
  input  logic [TI_W-1:0]  rl_idx,
  input  logic             rl_alt,
  input  logic [CNT_W-1:0] rl_val,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_addr,
  input  logic [CFG_W:0]   mem_wdata,
  input  logic [BK_W-1:0]  bank_sel,
  input  logic             step_done,
  output logic [N_TMR-1:0] tmr_fire,
  output logic             seq_active,
  output logic [TI_W-1:0]  seq_timer,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_valid
);

  logic [N_TMR-1:0] expire;
  logic             take, grant_v, rd_en;
  logic [TI_W-1:0]  gnt_idx;
  logic [AW-1:0]    rd_addr;
  logic [CFG_W:0]   rd_data;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    wseq_timer #(.CNT_W(CNT_W), .TI_W(TI_W), .IDX(g)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .en       (tmr_en[g]),
      .rate_sel (rate_sel[g]),
      .rl_we    (rl_we),
      .rl_idx   (rl_idx),
      .rl_alt   (rl_alt),
      .rl_val   (rl_val),
      .expire   (expire[g]),
      .fire     (tmr_fire[g])
    );
  end

  wseq_arbiter #(.N_TMR(N_TMR), .TI_W(TI_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .expire  (expire),
    .take    (take),
    .grant_v (grant_v),
    .gnt_idx (gnt_idx)
  );

  wseq_setup_mem #(.AW(AW), .DW(CFG_W + 1)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  wseq_engine #(
    .TI_W(TI_W), .BK_W(BK_W), .ST_W(ST_W), .N_STEP(N_STEP), .CFG_W(CFG_W)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .grant_v    (grant_v),
    .gnt_idx    (gnt_idx),
    .bank_sel   (bank_sel),
    .step_done  (step_done),
    .rd_data    (rd_data),
    .take       (take),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .seq_active (seq_active),
    .seq_timer  (seq_timer),
    .cfg_word   (cfg_word),
    .cfg_valid  (cfg_valid)
  );

endmodule

// File: tb/wakeup_sequencer_tb.sv
module wakeup_sequencer_tb;

  localparam int N_TMR  = 4;
  localparam int CNT_W  = 16;
  localparam int N_STEP = 4;
  localparam int CFG_W  = 16;
  localparam int NVEC   = 6;

  // vector fields: [1:0] timer, [2] bank, [3] rate, [11:4] normal, [19:12] alternate
  localparam logic [31:0] VEC [NVEC] = '{
    {12'd0, 8'd7, 8'd3, 1'b0, 1'b0, 2'd0},
    {12'd0, 8'd5, 8'd2, 1'b1, 1'b0, 2'd1},
    {12'd0, 8'd1, 8'd4, 1'b0, 1'b1, 2'd2},
    {12'd0, 8'd2, 8'd6, 1'b1, 1'b0, 2'd3},
    {12'd0, 8'd9, 8'd0, 1'b0, 1'b1, 2'd1},
    {12'd0, 8'd0, 8'd8, 1'b1, 1'b0, 2'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_TMR-1:0] tmr_en = '0, rate_sel = '0;
  logic             rl_we = 1'b0, rl_alt = 1'b0;
  logic [1:0]       rl_idx = '0;
  logic [CNT_W-1:0] rl_val = '0;
  logic             mem_we = 1'b0;
  logic [4:0]       mem_addr = '0;
  logic [CFG_W:0]   mem_wdata = '0;
  logic [0:0]       bank_sel = '0;
  logic             step_done = 1'b0;
  logic [N_TMR-1:0] tmr_fire;
  logic             seq_active, cfg_valid;
  logic [1:0]       seq_timer;
  logic [CFG_W-1:0] cfg_word;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  wakeup_sequencer u_dut (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .rate_sel(rate_sel),
    .rl_we(rl_we), .rl_idx(rl_idx), .rl_alt(rl_alt), .rl_val(rl_val),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .bank_sel(bank_sel), .step_done(step_done), .tmr_fire(tmr_fire),
    .seq_active(seq_active), .seq_timer(seq_timer), .cfg_word(cfg_word),
    .cfg_valid(cfg_valid)
  );

  function automatic logic [CFG_W-1:0] cfgv(input int b, input int t, input int s);
    return 16'hA000 | 16'(b << 8) | 16'(t << 4) | 16'(s);
  endfunction

  function automatic int seqlen(input int b, input int t);
    return ((t + b) % N_STEP) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tmr_en = '0; step_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic prog(input int t, input bit alt, input int val);
    @(negedge clk);
    rl_we = 1'b1; rl_idx = 2'(t); rl_alt = alt; rl_val = CNT_W'(val);
    @(negedge clk);
    rl_we = 1'b0;
  endtask

  task automatic fill_mem();
    for (int b = 0; b < 2; b++)
      for (int t = 0; t < N_TMR; t++)
        for (int s = 0; s < N_STEP; s++) begin
          @(negedge clk);
          mem_we = 1'b1;
          mem_addr = {1'(b), 2'(t), 2'(s)};
          mem_wdata = {(s == seqlen(b, t) - 1), cfgv(b, t, s)};
        end
    @(negedge clk); mem_we = 1'b0;
  endtask

  // waits at negedges for a timer fire, returns the number of edges seen
  task automatic wait_fire(input int t, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tmr_fire[t] && n < 400);
  endtask

  task automatic serve(input int t, input int b, input int len, input string endreq);
    int w = 0;
    while (!cfg_valid && w < 40) begin @(negedge clk); w++; end
    chk(seq_active && seq_timer == 2'(t), "R4", seq_timer, t);
    for (int s = 0; s < len; s++) begin
      chk(cfg_valid && cfg_word == cfgv(b, t, s), "R5", cfg_word, cfgv(b, t, s));
      step_done = 1'b1;
      @(negedge clk);
      step_done = 1'b0;
      if (s < len - 1) begin
        chk(!cfg_valid && seq_active, "R5", {cfg_valid, seq_active}, 1);
        @(negedge clk);
      end else begin
        chk(!seq_active && !cfg_valid, endreq, {seq_active, cfg_valid}, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int t, b, r, nv, av, per;
    do_reset();
    // R1: reset state and idle with all timers disabled
    chk(tmr_fire == '0 && !seq_active && !cfg_valid, "R1",
        {tmr_fire, seq_active, cfg_valid}, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (tmr_fire != '0 || seq_active) chk(1'b0, "R1", tmr_fire, 0);
    end
    chk(tmr_fire == '0 && !seq_active, "R1", seq_active, 0);
    fill_mem();

    // R11: done while idle has no effect
    @(negedge clk); step_done = 1'b1;
    repeat (3) @(negedge clk);
    step_done = 1'b0;
    chk(!seq_active && !cfg_valid, "R11", {seq_active, cfg_valid}, 0);

    // vector table walk: period, rate choice, start timing, word list
    for (int v = 0; v < NVEC; v++) begin
      t = int'(VEC[v][1:0]); b = int'(VEC[v][2]); r = int'(VEC[v][3]);
      nv = int'(VEC[v][11:4]); av = int'(VEC[v][19:12]);
      per = (r != 0) ? av + 1 : nv + 1;
      prog(t, 1'b0, nv);
      prog(t, 1'b1, av);
      rate_sel[t] = r[0]; bank_sel = b[0];
      repeat (2) @(negedge clk);
      tmr_en[t] = 1'b1;
      wait_fire(t, n);
      chk(n == per, (r != 0) ? "R3" : "R2", n, per);
      tmr_en[t] = 1'b0;
      @(negedge clk);
      chk(seq_active && !cfg_valid, "R4", {seq_active, cfg_valid}, 2);
      @(negedge clk);
      chk(cfg_valid, "R4", cfg_valid, 1);
      serve(t, b, seqlen(b, t), "R6");
    end

    // R2: automatic reload keeps firing every R+1 cycles
    do_reset();
    rate_sel = '0; bank_sel = 1'b0;
    prog(0, 1'b0, 2);
    repeat (2) @(negedge clk);
    tmr_en[0] = 1'b1;
    wait_fire(0, n);
    chk(n == 3, "R2", n, 3);
    wait_fire(0, n);
    chk(n == 3, "R2", n, 3);
    wait_fire(0, n);
    chk(n == 3, "R2", n, 3);

    // R9 R10 R8: simultaneous fire, queued timer, bank change mid-sequence
    do_reset();
    rate_sel = '0; bank_sel = 1'b0;
    prog(1, 1'b0, 4);
    prog(2, 1'b0, 4);
    repeat (2) @(negedge clk);
    tmr_en = 4'b0110;
    wait_fire(1, n);
    chk(tmr_fire == 4'b0110, "R9", tmr_fire, 4'b0110);
    tmr_en = '0;
    @(negedge clk);
    chk(seq_active && seq_timer == 2'd1, "R9", seq_timer, 1);
    bank_sel = 1'b1;
    serve(1, 0, seqlen(0, 1), "R8");
    @(negedge clk);
    chk(seq_active && seq_timer == 2'd2, "R10", {seq_active, seq_timer}, 6);
    serve(2, 1, seqlen(1, 2), "R10");

    // R7: no end flag in any word, sequence stops after N_STEP words
    for (int s = 0; s < N_STEP; s++) begin
      @(negedge clk);
      mem_we = 1'b1; mem_addr = {1'b1, 2'd3, 2'(s)};
      mem_wdata = {1'b0, cfgv(1, 3, s)};
    end
    @(negedge clk); mem_we = 1'b0;
    prog(3, 1'b0, 1);
    bank_sel = 1'b1; rate_sel = '0;
    repeat (2) @(negedge clk);
    tmr_en[3] = 1'b1;
    wait_fire(3, n);
    tmr_en[3] = 1'b0;
    serve(3, 1, N_STEP, "R7");
    repeat (3) @(negedge clk);
    chk(!seq_active, "R7", seq_active, 0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule